// File: doc/BRIEF.md
# Long-Exposure Field Sequencer

This block sits in the vertical section of a CCD sensor timing generator and decides, field by field, whether the sensor is read out, when the electronic shutter sweeps the photodiodes, and whether the incoming vertical reference is passed on as the internal vertical sync. In monitoring mode it reads out once per field. In still mode it runs a repeating still period of three or four fields. A pin selects the period length and an internal phase counter tracks the position within the period.

The vertical sync can be hidden over several fields for long exposures. A VD-control pin is sampled on each rising edge of the vertical reference. If that pin is low, the whole VD pulse is suppressed. This masking takes effect only when still mode is enabled and the programmed exposed-field count is two or more. Otherwise the pin is ignored. The shutter sweep strobe follows the edge that starts an exposure after a programmable number of clock cycles.

Top module: `lxf_field_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `vd_out`, `readout_en`, `sweep_en` are 0 and `still_phase` is 0 after that edge.
- R2: If `vd_ctrl` is 1 at the clock edge where a rising edge of `vd_in` is first seen, `vd_out` copies `vd_in` delayed by one clock for that whole pulse.
- R3: If `still_en` is 1, `exp_fields` is at least 2 and `vd_ctrl` is 0 at the edge where a VD rise is first seen, `vd_out` stays 0 for that entire pulse, even if `vd_ctrl` changes during the pulse.
- R4: If `still_en` is 0 or `exp_fields` is below 2, `vd_ctrl` has no effect and `vd_out` follows `vd_in` as in R2.
- R5: With `still_en` = 0, every VD rise gives a one-clock `readout_en` strobe in the same cycle that `vd_out` rises, and `still_phase` stays 0.
- R6: With `still_en` = 1, `still_phase` (2-bit binary) advances by one on every VD rise, masked or not, and wraps to 0 after 2 when `drive_mode` = 0 (3-field period) or after 3 when `drive_mode` = 1 (4-field period). It does not change between rises.
- R7: With `still_en` = 1, `readout_en` strobes for one clock only on the VD rise that returns `still_phase` to 0.
- R8: An exposure start is any VD rise when `still_en` = 0, or a VD rise at `still_phase` 0 when `still_en` = 1. Exactly `shutter_step` clocks after the `readout_en`/`vd_out` cycle of that start, `sweep_en` strobes for one clock. If `shutter_step` is 0, no strobe occurs. A newer start reloads the count.
- R9: A clock edge with `still_en` = 0 sets `still_phase` to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| vd_in | input | 1 | Incoming vertical reference pulse (active high) |
| vd_ctrl | input | 1 | VD-control: 0 requests masking of the next VD pulse |
| drive_mode | input | 1 | Still period: 0 = 3 fields, 1 = 4 fields |
| still_en | input | 1 | Still/integration mode enable |
| exp_fields | input | FIELD_W (3) | Number of exposed fields |
| shutter_step | input | STEP_W (7) | Shutter sweep delay in clocks |
| vd_out | output | 1 | Masked internal vertical sync |
| readout_en | output | 1 | Readout strobe, one clock |
| sweep_en | output | 1 | Shutter sweep strobe, one clock |
| still_phase | output | 2 | Field position within still period |

## Verification
The hardest case to reach is a VD pulse that is masked in the middle of a still period while `vd_ctrl` changes during that pulse. It requires still mode, a field count of at least two, the phase counter part-way through its period, and a control pin that toggles after the latching edge. The bench walks the phase counter through full 4-field and 3-field periods with masking active. In one masked pulse it raises `vd_ctrl` after the rise and confirms that `vd_out` stays low for the rest of the pulse while the phase still advances. The sweep delay is checked cycle by cycle in both modes, and one check confirms that a non-starting field gives no sweep.

// File: rtl/lxf_pkg.sv
package lxf_pkg;
  typedef logic [1:0] phase_t;

  // last phase value of a still period: 2 for three fields, 3 for four
  function automatic phase_t period_last(input logic four_field);
    return four_field ? 2'd3 : 2'd2;
  endfunction
endpackage

// File: rtl/lxf_vd_gate.sv
module lxf_vd_gate #(
  parameter int FIELD_W    = 3,
  parameter int MIN_FIELDS = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vd_in,
  input  logic               vd_ctrl,
  input  logic               still_en,
  input  logic [FIELD_W-1:0] exp_fields,
  output logic               vd_rise,
  output logic               vd_out
);
  localparam logic [FIELD_W-1:0] MinCnt = FIELD_W'(MIN_FIELDS);

  logic vd_q;
  logic mask_q;
  logic mask_ok;
  logic mask_new;

  assign mask_ok  = still_en && (exp_fields >= MinCnt);
  assign mask_new = mask_ok && !vd_ctrl;
  assign vd_rise  = vd_in && !vd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      vd_q   <= 1'b0;
      mask_q <= 1'b0;
      vd_out <= 1'b0;
    end else begin
      vd_q <= vd_in;
      if (vd_rise) begin
        mask_q <= mask_new;
        vd_out <= vd_in && !mask_new;
      end else begin
        vd_out <= vd_in && !mask_q;
      end
    end
  end

  p_pass_r2: assert property (@(posedge clk) disable iff (rst)
    (vd_rise && vd_ctrl) |=> vd_out);
  p_src_r2: assert property (@(posedge clk) disable iff (rst)
    vd_out |-> $past(vd_in));
  p_mask_r3: assert property (@(posedge clk) disable iff (rst)
    (vd_rise && !vd_ctrl && still_en && exp_fields >= MinCnt) |=> !vd_out);
  p_ignore_r4: assert property (@(posedge clk) disable iff (rst)
    (vd_rise && !still_en) |=> vd_out);
endmodule

// File: rtl/lxf_phase.sv
module lxf_phase
  import lxf_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   vd_rise,
  input  logic   still_en,
  input  logic   drive_mode,
  output phase_t phase_q,
  output logic   readout_en,
  output logic   exp_start
);
  phase_t last;

  assign last      = period_last(drive_mode);
  assign exp_start = vd_rise && (!still_en || phase_q == 2'd0);

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= 2'd0;
      readout_en <= 1'b0;
    end else if (!still_en) begin
      phase_q    <= 2'd0;
      readout_en <= vd_rise;
    end else begin
      readout_en <= 1'b0;
      if (vd_rise) begin
        if (phase_q >= last) begin
          phase_q    <= 2'd0;
          readout_en <= 1'b1;
        end else begin
          phase_q <= phase_q + 2'd1;
        end
      end
    end
  end

  p_ro_edge_r7: assert property (@(posedge clk) disable iff (rst)
    readout_en |-> $past(vd_rise));
  p_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (still_en && !vd_rise) |=> $stable(phase_q));
  p_wrap_r6: assert property (@(posedge clk) disable iff (rst)
    (still_en && vd_rise && !drive_mode && phase_q == 2'd2) |=> phase_q == 2'd0);
  p_exit_r9: assert property (@(posedge clk) disable iff (rst)
    !still_en |=> phase_q == 2'd0);
endmodule

// File: rtl/lxf_shutter.sv
module lxf_shutter #(
  parameter int STEP_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [STEP_W-1:0] step,
  output logic              sweep_en
);
  localparam logic [STEP_W-1:0] One = STEP_W'(1);

  logic [STEP_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt      <= '0;
      sweep_en <= 1'b0;
    end else begin
      sweep_en <= (cnt == One);
      if (start)
        cnt <= step;
      else if (cnt != '0)
        cnt <= cnt - One;
    end
  end

  p_sweep_r8: assert property (@(posedge clk) disable iff (rst)
    sweep_en |-> $past(cnt) == One);
  p_zero_r8: assert property (@(posedge clk) disable iff (rst)
    (start && step == '0) |=> cnt == '0);
endmodule

// File: rtl/lxf_field_seq.sv
module lxf_field_seq #(
  parameter int FIELD_W    = 3,
  parameter int STEP_W     = 7,
  parameter int MIN_FIELDS = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               vd_in,
  input  logic               vd_ctrl,
  input  logic               drive_mode,
  input  logic               still_en,
  input  logic [FIELD_W-1:0] exp_fields,
  input  logic [STEP_W-1:0]  shutter_step,
  output logic               vd_out,
  output logic               readout_en,
  output logic               sweep_en,
  output logic [1:0]         still_phase
);
  logic vd_rise;
  logic exp_start;

  lxf_vd_gate #(.FIELD_W(FIELD_W), .MIN_FIELDS(MIN_FIELDS)) u_gate (
    .clk(clk), .rst(rst), .vd_in(vd_in), .vd_ctrl(vd_ctrl),
    .still_en(still_en), .exp_fields(exp_fields),
    .vd_rise(vd_rise), .vd_out(vd_out)
  );

  lxf_phase u_phase (
    .clk(clk), .rst(rst), .vd_rise(vd_rise), .still_en(still_en),
    .drive_mode(drive_mode), .phase_q(still_phase),
    .readout_en(readout_en), .exp_start(exp_start)
  );

  lxf_shutter #(.STEP_W(STEP_W)) u_shutter (
    .clk(clk), .rst(rst), .start(exp_start), .step(shutter_step),
    .sweep_en(sweep_en)
  );

  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!vd_out && !readout_en && !sweep_en && still_phase == 2'd0));
endmodule

// File: tb/lxf_field_seq_bench.sv
module lxf_field_seq_bench;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       vd_in = 1'b0;
  logic       vd_ctrl = 1'b1;
  logic       drive_mode = 1'b1;
  logic       still_en = 1'b0;
  logic [2:0] exp_fields = 3'd0;
  logic [6:0] shutter_step = 7'd0;
  logic       vd_out, readout_en, sweep_en;
  logic [1:0] still_phase;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lxf_field_seq u_lxf_field_seq (
    .clk(clk), .rst(rst), .vd_in(vd_in), .vd_ctrl(vd_ctrl),
    .drive_mode(drive_mode), .still_en(still_en), .exp_fields(exp_fields),
    .shutter_step(shutter_step), .vd_out(vd_out), .readout_en(readout_en),
    .sweep_en(sweep_en), .still_phase(still_phase)
  );

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // one VD pulse; outputs checked on the clock after the rise is seen
  task automatic vd_pulse(input bit ev, input bit ero, input int eph,
                          input bit flip, input string req);
    @(negedge clk) vd_in = 1'b1;
    @(negedge clk);
    chk(vd_out, ev, {req, " vd_out at rise"});
    chk(readout_en, ero, {req, " readout_en"});
    chk(still_phase, eph, {req, " still_phase"});
    if (flip) vd_ctrl = ~vd_ctrl;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(vd_out, ev, {req, " vd_out held"});
      chk(readout_en, 0, {req, " readout one clock"});
    end
    vd_in = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // VD pulse with cycle-by-cycle sweep check; sweep expected s clocks after the start cycle
  task automatic sweep_pulse(input int s, input bit ero, input int eph, input string req);
    @(negedge clk) vd_in = 1'b1;
    for (int k = 1; k <= 12; k++) begin
      @(negedge clk);
      if (k == 1) begin
        chk(readout_en, ero, {req, " readout_en"});
        chk(still_phase, eph, {req, " still_phase"});
      end
      if (k == 3) vd_in = 1'b0;
      chk(sweep_en, (s != 0 && k == s + 1) ? 1 : 0, {req, " sweep_en timing"});
    end
  endtask

  task automatic t_reset;
    vd_in = 1'b1;
    repeat (3) @(negedge clk);
    chk(vd_out, 0, "R1 vd_out");
    chk(readout_en, 0, "R1 readout_en");
    chk(sweep_en, 0, "R1 sweep_en");
    chk(still_phase, 0, "R1 still_phase");
    vd_in = 1'b0;
    @(negedge clk) rst = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic t_monitor;
    vd_ctrl = 1'b1; still_en = 1'b0;
    vd_pulse(1, 1, 0, 0, "R2/R5 monitoring");
    vd_pulse(1, 1, 0, 0, "R5 second field");
  endtask

  task automatic t_ignore;
    vd_ctrl = 1'b0; still_en = 1'b0; exp_fields = 3'd5;
    vd_pulse(1, 1, 0, 0, "R4 still off");
    still_en = 1'b1; exp_fields = 3'd1; drive_mode = 1'b1;
    vd_pulse(1, 0, 1, 0, "R4 one field");
  endtask

  task automatic t_mask_four;
    exp_fields = 3'd3; vd_ctrl = 1'b0;
    vd_pulse(0, 0, 2, 0, "R3/R6 masked");
    vd_pulse(0, 0, 3, 1, "R3 ctrl flips mid pulse");
    vd_ctrl = 1'b0;
    vd_pulse(0, 1, 0, 0, "R7 four-field wrap");
    vd_ctrl = 1'b1;
    vd_pulse(1, 0, 1, 0, "R2 still unmasked");
  endtask

  task automatic t_three;
    drive_mode = 1'b0;
    vd_pulse(1, 0, 2, 0, "R6 three-field");
    vd_pulse(1, 1, 0, 0, "R7 three-field wrap");
    vd_pulse(1, 0, 1, 0, "R6 three-field p1");
    vd_pulse(1, 0, 2, 0, "R6 three-field p2");
    vd_pulse(1, 1, 0, 0, "R7 three-field wrap 2");
  endtask

  task automatic t_exit;
    vd_pulse(1, 0, 1, 0, "R6 before exit");
    @(negedge clk) still_en = 1'b0;
    @(negedge clk);
    chk(still_phase, 0, "R9 phase cleared");
    vd_pulse(1, 1, 0, 0, "R9 back to monitoring");
  endtask

  task automatic t_sweep;
    shutter_step = 7'd5;
    sweep_pulse(5, 1, 0, "R8 monitoring step 5");
    shutter_step = 7'd0;
    sweep_pulse(0, 1, 0, "R8 step 0");
    still_en = 1'b1; drive_mode = 1'b1; exp_fields = 3'd1; shutter_step = 7'd3;
    @(negedge clk);
    sweep_pulse(3, 0, 1, "R8 still start");
    sweep_pulse(0, 0, 2, "R8 still non-start");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got 0 expected 1 (run did not finish)");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_monitor();
    t_ignore();
    t_mask_four();
    t_three();
    t_exit();
    t_sweep();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule